// File: doc/BRIEF.md
# Conditional Relative Branch Unit

This block decides whether a near branch is taken and produces the next instruction pointer together with the 20-bit fetch address for the same code segment. A request presents a condition code, the five arithmetic flags, the instruction pointer of the next sequential instruction, a displacement and the code segment base. One cycle later the block reports whether the branch is taken. It also reports the resulting instruction pointer and the physical fetch address. The flags are passed through unchanged.

Conditional branches use an 8-bit signed displacement that is sign-extended and added to the instruction pointer. The unconditional jump may use either the short 8-bit form or the full 16-bit form. When the condition is false, the instruction pointer is left at the next sequential instruction. The fetch address is the segment base shifted left by four bits plus the resulting instruction pointer.

Top module: `rel_branch_unit`

## Requirements
- R1: While reset is asserted and after it is released, `res_valid`, `taken`, `ip_out`, `fetch_addr` and `flags_out` are all zero until the first request.
- R2: A request accepted on a rising edge (`req_valid`=1) makes `res_valid` high for exactly the following cycle. Without a request, `res_valid` is low and `taken`, `ip_out`, `fetch_addr` and `flags_out` hold their previous values.
- R3: For a conditional code (1 to 16) whose condition holds, `ip_out` = `ip_in` + sign-extended `disp_in[7:0]`, modulo 2^16. `disp_in[15:8]` and `disp_wide` have no effect.
- R4: Code 0 is the unconditional jump and is always taken. With `disp_wide`=1 it adds all 16 bits of `disp_in`; with `disp_wide`=0 it adds sign-extended `disp_in[7:0]`. Both sums wrap modulo 2^16.
- R5: When the branch is not taken, `ip_out` equals the `ip_in` of the request.
- R6: `fetch_addr` = (`cs_in` × 16 + `ip_out`) modulo 2^20.
- R7: The flag bits are `flags_in[0]`=CF, `[1]`=PF, `[2]`=ZF, `[3]`=SF, `[4]`=OF. Each single-flag test uses two codes. Flag bit i is tested for 1 by code 2i+1 and for 0 by code 2i+2. So CF=1 (also "below") is code 1, CF=0 is code 2, PF is codes 3 and 4, ZF=1 ("equal"/"zero") is code 5, ZF=0 is code 6, SF is codes 7 and 8, and OF is codes 9 and 10.
- R8: The unsigned composites are code 11 (above: CF=0 and ZF=0) and code 12 (below-or-equal: CF=1 or ZF=1).
- R9: The signed composites are code 13 (less: SF≠OF), code 14 (greater-or-equal: SF=OF), code 15 (less-or-equal: ZF=1 or SF≠OF) and code 16 (greater: ZF=0 and SF=OF).
- R10: Codes 17 to 31 are never taken.
- R11: `flags_out` equals the `flags_in` of the request; the branch changes no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request strobe |
| cond_code | input | 5 | Branch condition selector |
| flags_in | input | 5 | OF, SF, ZF, PF, CF (bit 4 down to bit 0) |
| ip_in | input | 16 | Instruction pointer of the next sequential instruction |
| disp_in | input | 16 | Displacement; only bits 7:0 are used except for the wide unconditional jump |
| disp_wide | input | 1 | Selects the 16-bit displacement for code 0 |
| cs_in | input | 16 | Code segment base |
| res_valid | output | 1 | Result strobe, one cycle after the request |
| taken | output | 1 | Branch taken |
| ip_out | output | 16 | Resulting instruction pointer |
| fetch_addr | output | 20 | Physical fetch address |
| flags_out | output | 5 | Flags of the request, unchanged |

## Verification
Every result is due on the rising edge after the request edge: `res_valid`, `taken`, `ip_out`, `fetch_addr` and `flags_out` all come from one register stage. The bench drives a request on a falling edge and removes it on the next falling edge. It compares all outputs at that second falling edge, which is half a period after the register loads. In the hold checks, it samples again one falling edge later to confirm that `res_valid` has dropped and the other outputs have not moved.

// File: rtl/rbu_pkg.sv
package rbu_pkg;
  localparam int unsigned FLAG_N = 5;
  localparam int unsigned CC_W   = 5;

  localparam int unsigned FL_CF = 0;
  localparam int unsigned FL_PF = 1;
  localparam int unsigned FL_ZF = 2;
  localparam int unsigned FL_SF = 3;
  localparam int unsigned FL_OF = 4;

  // single-flag codes occupy 1 .. 2*FLAG_N, composites follow
  localparam logic [CC_W-1:0] CC_ALWAYS    = 5'd0;
  localparam logic [CC_W-1:0] CC_SINGLE_LO = 5'd1;
  localparam logic [CC_W-1:0] CC_SINGLE_HI = 5'(2*FLAG_N);
  localparam logic [CC_W-1:0] CC_ABOVE     = 5'd11;
  localparam logic [CC_W-1:0] CC_BEL_EQ    = 5'd12;
  localparam logic [CC_W-1:0] CC_LESS      = 5'd13;
  localparam logic [CC_W-1:0] CC_GR_EQ     = 5'd14;
  localparam logic [CC_W-1:0] CC_LESS_EQ   = 5'd15;
  localparam logic [CC_W-1:0] CC_GREATER   = 5'd16;
endpackage

// File: rtl/rbu_cond_eval.sv
module rbu_cond_eval
  import rbu_pkg::*;
(
  input  logic [CC_W-1:0]   cc,
  input  logic [FLAG_N-1:0] flags,
  output logic              is_uncond,
  output logic              cond_true
);
  localparam int unsigned SINGLE_N = 2 * FLAG_N;
  localparam int unsigned SIDX_W   = $clog2(SINGLE_N);

  logic [SINGLE_N-1:0] single_hit;
  logic [CC_W-1:0]     sidx_full;
  logic                sf_ne_of;

  genvar gi;
  generate
    for (gi = 0; gi < FLAG_N; gi++) begin : g_flag
      assign single_hit[2*gi]   = flags[gi];
      assign single_hit[2*gi+1] = ~flags[gi];
    end
  endgenerate

  assign sidx_full = cc - CC_SINGLE_LO;
  assign sf_ne_of  = flags[FL_SF] ^ flags[FL_OF];
  assign is_uncond = (cc == CC_ALWAYS);

  always_comb begin
    cond_true = 1'b0;
    if (cc >= CC_SINGLE_LO && cc <= CC_SINGLE_HI) begin
      cond_true = single_hit[sidx_full[SIDX_W-1:0]];
    end else begin
      case (cc)
        CC_ABOVE:   cond_true = ~flags[FL_CF] & ~flags[FL_ZF];
        CC_BEL_EQ:  cond_true = flags[FL_CF] | flags[FL_ZF];
        CC_LESS:    cond_true = sf_ne_of;
        CC_GR_EQ:   cond_true = ~sf_ne_of;
        CC_LESS_EQ: cond_true = flags[FL_ZF] | sf_ne_of;
        CC_GREATER: cond_true = ~flags[FL_ZF] & ~sf_ne_of;
        default:    cond_true = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/rbu_target_calc.sv
module rbu_target_calc #(
  parameter int unsigned IP_W      = 16,
  parameter int unsigned NARROW_W  = 8,
  parameter int unsigned SEG_SHIFT = 4,
  localparam int unsigned ADDR_W   = IP_W + SEG_SHIFT
) (
  input  logic [IP_W-1:0]   ip,
  input  logic [IP_W-1:0]   disp,
  input  logic              use_wide,
  input  logic              take,
  input  logic [IP_W-1:0]   seg,
  output logic [IP_W-1:0]   next_ip,
  output logic [ADDR_W-1:0] phys
);
  function automatic logic [IP_W-1:0] sext_short(input logic [IP_W-1:0] d);
    return {{(IP_W-NARROW_W){d[NARROW_W-1]}}, d[NARROW_W-1:0]};
  endfunction

  function automatic logic [IP_W-1:0] ip_add(input logic [IP_W-1:0] a,
                                             input logic [IP_W-1:0] b);
    return a + b;
  endfunction

  function automatic logic [ADDR_W-1:0] seg_addr(input logic [IP_W-1:0] s,
                                                 input logic [IP_W-1:0] off);
    return {s, {SEG_SHIFT{1'b0}}} + {{SEG_SHIFT{1'b0}}, off};
  endfunction

  logic [IP_W-1:0] disp_ext;
  logic [IP_W-1:0] target;

  assign disp_ext = use_wide ? disp : sext_short(disp);
  assign target   = ip_add(ip, disp_ext);
  assign next_ip  = take ? target : ip;
  assign phys     = seg_addr(seg, next_ip);
endmodule

// File: rtl/rbu_result_stage.sv
module rbu_result_stage
  import rbu_pkg::*;
#(
  parameter int unsigned IP_W   = 16,
  parameter int unsigned ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              take_d,
  input  logic [IP_W-1:0]   ip_d,
  input  logic [ADDR_W-1:0] addr_d,
  input  logic [FLAG_N-1:0] flags_d,
  output logic              valid_q,
  output logic              take_q,
  output logic [IP_W-1:0]   ip_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic [FLAG_N-1:0] flags_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      take_q  <= 1'b0;
      ip_q    <= '0;
      addr_q  <= '0;
      flags_q <= '0;
    end else begin
      valid_q <= load;
      if (load) begin
        take_q  <= take_d;
        ip_q    <= ip_d;
        addr_q  <= addr_d;
        flags_q <= flags_d;
      end
    end
  end
endmodule

// File: rtl/rel_branch_unit.sv
module rel_branch_unit
  import rbu_pkg::*;
#(
  parameter int unsigned IP_W      = 16,
  parameter int unsigned NARROW_W  = 8,
  parameter int unsigned SEG_SHIFT = 4,
  localparam int unsigned ADDR_W   = IP_W + SEG_SHIFT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [CC_W-1:0]   cond_code,
  input  logic [FLAG_N-1:0] flags_in,
  input  logic [IP_W-1:0]   ip_in,
  input  logic [IP_W-1:0]   disp_in,
  input  logic              disp_wide,
  input  logic [IP_W-1:0]   cs_in,
  output logic              res_valid,
  output logic              taken,
  output logic [IP_W-1:0]   ip_out,
  output logic [ADDR_W-1:0] fetch_addr,
  output logic [FLAG_N-1:0] flags_out
);
  logic              is_uncond;
  logic              cond_true;
  logic              take_now;
  logic              wide_now;
  logic [IP_W-1:0]   next_ip;
  logic [ADDR_W-1:0] next_addr;

  rbu_cond_eval u_cond (
    .cc        (cond_code),
    .flags     (flags_in),
    .is_uncond (is_uncond),
    .cond_true (cond_true)
  );

  assign take_now = is_uncond | cond_true;
  assign wide_now = is_uncond & disp_wide;

  rbu_target_calc #(
    .IP_W      (IP_W),
    .NARROW_W  (NARROW_W),
    .SEG_SHIFT (SEG_SHIFT)
  ) u_tgt (
    .ip       (ip_in),
    .disp     (disp_in),
    .use_wide (wide_now),
    .take     (take_now),
    .seg      (cs_in),
    .next_ip  (next_ip),
    .phys     (next_addr)
  );

  rbu_result_stage #(
    .IP_W   (IP_W),
    .ADDR_W (ADDR_W)
  ) u_res (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (req_valid),
    .take_d  (take_now),
    .ip_d    (next_ip),
    .addr_d  (next_addr),
    .flags_d (flags_in),
    .valid_q (res_valid),
    .take_q  (taken),
    .ip_q    (ip_out),
    .addr_q  (fetch_addr),
    .flags_q (flags_out)
  );
endmodule

// File: rtl/rel_branch_unit_chk.sv
module rel_branch_unit_chk
  import rbu_pkg::*;
#(
  parameter int unsigned IP_W      = 16,
  parameter int unsigned SEG_SHIFT = 4,
  localparam int unsigned ADDR_W   = IP_W + SEG_SHIFT
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic [CC_W-1:0]   cond_code,
  input logic [FLAG_N-1:0] flags_in,
  input logic [IP_W-1:0]   ip_in,
  input logic [IP_W-1:0]   cs_in,
  input logic              cond_true,
  input logic              res_valid,
  input logic              taken,
  input logic [IP_W-1:0]   ip_out,
  input logic [ADDR_W-1:0] fetch_addr,
  input logic [FLAG_N-1:0] flags_out
);
  a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> res_valid);
  a_r2_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !res_valid);
  a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> ($stable(ip_out) && $stable(fetch_addr) && $stable(taken)));
  a_r4_uncond_taken: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && cond_code == CC_ALWAYS) |=> taken);
  a_r5_not_taken_ip: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && cond_code != CC_ALWAYS && !cond_true) |=> (!taken && ip_out == $past(ip_in)));
  a_r6_fetch_addr: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> fetch_addr == ({$past(cs_in), {SEG_SHIFT{1'b0}}} + {{SEG_SHIFT{1'b0}}, ip_out}));
  a_r10_undefined: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && cond_code > CC_GREATER) |=> !taken);
  a_r11_flags_kept: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> flags_out == $past(flags_in));
endmodule

bind rel_branch_unit rel_branch_unit_chk #(
  .IP_W      (IP_W),
  .SEG_SHIFT (SEG_SHIFT)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .cond_code  (cond_code),
  .flags_in   (flags_in),
  .ip_in      (ip_in),
  .cs_in      (cs_in),
  .cond_true  (cond_true),
  .res_valid  (res_valid),
  .taken      (taken),
  .ip_out     (ip_out),
  .fetch_addr (fetch_addr),
  .flags_out  (flags_out)
);

// File: tb/rel_branch_unit_tb.sv
`timescale 1ns/1ps
module rel_branch_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [4:0]  cond_code = '0;
  logic [4:0]  flags_in = '0;
  logic [15:0] ip_in = '0;
  logic [15:0] disp_in = '0;
  logic        disp_wide = 1'b0;
  logic [15:0] cs_in = '0;
  logic        res_valid, taken;
  logic [15:0] ip_out;
  logic [19:0] fetch_addr;
  logic [4:0]  flags_out;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  rel_branch_unit u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .cond_code(cond_code),
    .flags_in(flags_in), .ip_in(ip_in), .disp_in(disp_in), .disp_wide(disp_wide),
    .cs_in(cs_in), .res_valid(res_valid), .taken(taken), .ip_out(ip_out),
    .fetch_addr(fetch_addr), .flags_out(flags_out)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // model of the condition table, written flag by flag
  function automatic bit model_cond(input int code, input logic [4:0] f);
    bit c = f[0], p = f[1], z = f[2], s = f[3], o = f[4];
    case (code)
      0:  return 1;
      1:  return c;       2:  return !c;
      3:  return p;       4:  return !p;
      5:  return z;       6:  return !z;
      7:  return s;       8:  return !s;
      9:  return o;       10: return !o;
      11: return !c && !z;
      12: return c || z;
      13: return s != o;
      14: return s == o;
      15: return z || (s != o);
      16: return !z && (s == o);
      default: return 0;
    endcase
  endfunction

  task automatic request(input string req, input int code, input logic [4:0] f,
                         input logic [15:0] ip, input logic [15:0] d,
                         input logic w, input logic [15:0] cs);
    int dv, tip;
    bit tk;
    tk = model_cond(code, f);
    if (code == 0 && w) dv = int'(d);
    else dv = int'($signed(d[7:0]));
    tip = tk ? ((int'(ip) + dv) & 32'hFFFF) : int'(ip);
    @(negedge clk);
    req_valid = 1'b1; cond_code = 5'(code); flags_in = f;
    ip_in = ip; disp_in = d; disp_wide = w; cs_in = cs;
    @(negedge clk);
    req_valid = 1'b0;
    check({req, " R2 valid"}, 32'(res_valid), 32'd1);
    check({req, " taken"}, 32'(taken), 32'(tk));
    check({req, " ip"}, 32'(ip_out), 32'(tip));
    check({req, " R6 fetch"}, 32'(fetch_addr), 32'((int'(cs) * 16 + tip) & 32'hFFFFF));
    check({req, " R11 flags"}, 32'(flags_out), 32'(f));
  endtask

  task automatic t_reset();
    check("R1 valid", 32'(res_valid), 0);
    check("R1 taken", 32'(taken), 0);
    check("R1 ip", 32'(ip_out), 0);
    check("R1 fetch", 32'(fetch_addr), 0);
    check("R1 flags", 32'(flags_out), 0);
  endtask

  task automatic t_single_flags();
    for (int code = 1; code <= 10; code++)
      for (int f = 0; f < 32; f++)
        request("R7", code, 5'(f), 16'h2000 + 16'(f), 16'hAB10 + 16'(code), 1'b1, 16'h0100);
  endtask

  task automatic t_composites();
    for (int f = 0; f < 32; f++) begin
      request("R8 above", 11, 5'(f), 16'h3000, 16'h0040, 1'b0, 16'h0200);
      request("R8 below_eq", 12, 5'(f), 16'h3000, 16'h00C0, 1'b0, 16'h0200);
      request("R9 less", 13, 5'(f), 16'h3100, 16'h0004, 1'b0, 16'h0300);
      request("R9 gr_eq", 14, 5'(f), 16'h3100, 16'h00FC, 1'b0, 16'h0300);
      request("R9 less_eq", 15, 5'(f), 16'h3200, 16'h0011, 1'b0, 16'h0400);
      request("R9 greater", 16, 5'(f), 16'h3200, 16'h00EE, 1'b0, 16'h0400);
    end
  endtask

  task automatic t_displacement();
    request("R3 wrap up", 5, 5'b00100, 16'hFFF0, 16'h0020, 1'b0, 16'h1000);
    request("R3 wrap down", 6, 5'b00000, 16'h0005, 16'h0080, 1'b0, 16'h1000);
    request("R3 high byte ignored", 1, 5'b00001, 16'h4000, 16'h7F7F, 1'b1, 16'h1000);
    request("R4 wide", 0, 5'b10101, 16'h1000, 16'h8000, 1'b1, 16'h2000);
    request("R4 short", 0, 5'b01010, 16'h1000, 16'h12F0, 1'b0, 16'h2000);
    request("R4 wide wrap", 0, 5'b00000, 16'hF000, 16'h2345, 1'b1, 16'h2000);
    request("R5 not taken", 2, 5'b00001, 16'h5555, 16'h0010, 1'b0, 16'h3000);
    request("R6 fetch wrap", 0, 5'b00000, 16'h0010, 16'h0010, 1'b0, 16'hFFFF);
  endtask

  task automatic t_undefined();
    for (int code = 17; code < 32; code++)
      request("R10", code, 5'(code), 16'h6000, 16'h0033, 1'b1, 16'h0500);
  endtask

  task automatic t_hold();
    logic [15:0] ip_keep;
    logic [19:0] fa_keep;
    request("R2 setup", 0, 5'b11111, 16'h7000, 16'h0010, 1'b0, 16'h0010);
    ip_keep = ip_out; fa_keep = fetch_addr;
    ip_in = 16'h1234; cs_in = 16'h4321; cond_code = 5'd0; flags_in = 5'b00000;
    @(negedge clk);
    check("R2 idle valid", 32'(res_valid), 0);
    check("R2 idle ip", 32'(ip_out), 32'(ip_keep));
    check("R2 idle fetch", 32'(fetch_addr), 32'(fa_keep));
    check("R2 idle flags", 32'(flags_out), 32'h1F);
    check("R2 idle taken", 32'(taken), 1);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_single_flags();
    t_composites();
    t_displacement();
    t_undefined();
    t_hold();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule